// File: doc/BRIEF.md
# Keyed One-Shot Diagnostic Control Register

This block is a safety control register that fires short diagnostic strobes toward an interconnect checker. It holds two 4-bit key fields. The first field requests that the checker invert its parity polarity. The second field requests a clear of the global error state. Each field rests at an idle key. When privileged software writes the trigger key into a field, the matching strobe goes high for one clock. The field then returns to the idle key without any further write, so normal memory traffic on later cycles is not disturbed.

The register has a single write port with a privilege qualifier and a combinational read port. Each 4-bit key value is ANDed with nothing and held as written. Only the trigger key and the idle key are accepted. Every other value leaves the field unchanged. Writes without privilege are dropped. The two fields act independently, and one bus write may address both of them.

Top module: `diag_key_ctrl`

## Requirements
- R1: After reset both key fields hold 0x5, `par_inv_o` and `err_clr_o` are low, and `rd_data_o` reads 0x0505_0000.
- R2: A privileged write with 0xA in bits [27:24] drives `par_inv_o` high in the cycle that follows the write edge.
- R3: Each accepted trigger write produces exactly one cycle of strobe. Back-to-back trigger writes keep the strobe high for one cycle per write.
- R4: After the strobe cycle the field returns to 0x5 by itself, and this is visible on `rd_data_o`.
- R5: A write with `wr_priv_i` low changes neither field and raises no strobe.
- R6: A key value other than 0xA or 0x5 is ignored, and the field keeps its value. A privileged write of 0x5 sets the field to 0x5, which also cancels a pending return.
- R7: The error-clear field at bits [19:16] behaves the same way with key 0xA and drives `err_clr_o`.
- R8: `rd_data_o` always shows the parity field at [27:24] and the error-clear field at [19:16]. All other bits read 0, whatever is written to them.
- R9: The two fields are independent. A single write can trigger either field alone or both at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_priv_i | input | 1 | Requester is in privileged mode |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current register contents |
| par_inv_o | output | 1 | One-cycle parity-polarity inversion strobe |
| err_clr_o | output | 1 | One-cycle global error clear strobe |

## Verification
A field that latched a bad key, or that failed to return to idle, shows up on `rd_data_o` on the next cycle. The same fault also appears as a strobe that stays high or never rises. A stuck privilege gate shows up one cycle after an unprivileged write, as a changed read value or a stray strobe. The bench runs a behavioural model in step with the design and compares both strobes and the full read word every cycle. It drives directed trigger, idle, illegal-key and back-to-back cases, followed by a long mixed stream of writes. This catches a divergence in the cycle it first appears.

// File: rtl/diag_key_pkg.sv
package diag_key_pkg;
  localparam int unsigned KEY_W    = 4;
  localparam int unsigned NUM_KEYS = 2;
  typedef logic [KEY_W-1:0] key_t;
  localparam key_t KEY_TRIG = 4'hA;
  localparam key_t KEY_IDLE = 4'h5;
  // field index order drives output mapping
  localparam int unsigned IDX_PAR = 0;
  localparam int unsigned IDX_ERR = 1;
endpackage

// File: rtl/diag_key_field.sv
module diag_key_field
  import diag_key_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_priv_i,
  input  key_t wr_key_i,
  output key_t key_o,
  output logic pulse_o
);
  key_t field_q;
  logic wr_ok;
  logic key_legal;

  assign wr_ok     = wr_en_i && wr_priv_i;
  assign key_legal = (wr_key_i == KEY_TRIG) || (wr_key_i == KEY_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  field_q <= KEY_IDLE;
    else if (wr_ok && key_legal)  field_q <= wr_key_i;
    else if (field_q == KEY_TRIG) field_q <= KEY_IDLE;
  end

  assign key_o   = field_q;
  assign pulse_o = (field_q == KEY_TRIG);

  a_r2_trigger_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && wr_key_i == KEY_TRIG) |=> pulse_o);
  a_r3_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && !(wr_ok && wr_key_i == KEY_TRIG)) |=> !pulse_o);
  a_r4_self_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && !(wr_ok && key_legal)) |=> (key_o == KEY_IDLE));
  a_r5_no_priv_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ok && !pulse_o) |=> $stable(key_o));
  a_r6_legal_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_o == KEY_IDLE) || (key_o == KEY_TRIG));
endmodule

// File: rtl/diag_key_ctrl.sv
module diag_key_ctrl
  import diag_key_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PAR_LSB = 24,
  parameter int unsigned ERR_LSB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_priv_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              par_inv_o,
  output logic              err_clr_o
);
  localparam int unsigned FIELD_LSB [NUM_KEYS] = '{PAR_LSB, ERR_LSB};

  key_t               keys  [NUM_KEYS];
  logic [NUM_KEYS-1:0] pulses;

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    diag_key_field u_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_priv_i (wr_priv_i),
      .wr_key_i  (wr_data_i[FIELD_LSB[g] +: KEY_W]),
      .key_o     (keys[g]),
      .pulse_o   (pulses[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_KEYS; i++) rd_data_o[FIELD_LSB[i] +: KEY_W] = keys[i];
  end

  assign par_inv_o = pulses[IDX_PAR];
  assign err_clr_o = pulses[IDX_ERR];

  a_r8_field_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[PAR_LSB +: KEY_W] == KEY_TRIG) == par_inv_o);
  a_r7_err_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[ERR_LSB +: KEY_W] == KEY_TRIG) == err_clr_o);
  a_r9_independent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_priv_i && wr_data_i[ERR_LSB +: KEY_W] == KEY_TRIG
     && wr_data_i[PAR_LSB +: KEY_W] == KEY_TRIG) |=> (par_inv_o && err_clr_o));
endmodule

// File: tb/tb_diag_key_ctrl.sv
module tb_diag_key_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, wr_priv = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        par_inv, err_clr;
  int          n_chk = 0, n_err = 0;
  int          m_par = 5, m_err = 5;
  bit          done = 0;

  always #5 clk = ~clk;

  diag_key_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_priv_i(wr_priv),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .par_inv_o(par_inv), .err_clr_o(err_clr)
  );

  function automatic int next_key(int cur, int k, bit acc);
    if (acc && (k == 10 || k == 5)) return k;
    if (cur == 10) return 5;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_par <= 5; m_err <= 5; end
    else begin
      m_par <= next_key(m_par, int'(wr_data[27:24]), wr_en && wr_priv);
      m_err <= next_key(m_err, int'(wr_data[19:16]), wr_en && wr_priv);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk("R3 par strobe", 32'(par_inv), 32'(m_par == 10));
    chk("R7 err strobe", 32'(err_clr), 32'(m_err == 10));
    chk("R8 read word", rd_data, (32'(m_par) << 24) | (32'(m_err) << 16));
  endtask

  task automatic step(bit w, bit p, logic [31:0] d);
    wr_en = w; wr_priv = p; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0; wr_priv = 0; wr_data = '0;
    model_cmp();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset read", rd_data, 32'h0505_0000);
    chk("R1 reset strobes", {30'd0, par_inv, err_clr}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R2 trigger parity
    step(1, 1, 32'h0A00_0000);
    chk("R2 par high", 32'(par_inv), 1);
    chk("R2 read A", rd_data, 32'h0A05_0000);
    step(0, 0, 0);
    chk("R3 par low", 32'(par_inv), 0);
    chk("R4 restored", rd_data, 32'h0505_0000);
    // R5 unprivileged
    step(1, 0, 32'h0A0A_0000);
    chk("R5 no strobe", {30'd0, par_inv, err_clr}, 0);
    chk("R5 read kept", rd_data, 32'h0505_0000);
    // R6 illegal key
    step(1, 1, 32'h0300_0000);
    chk("R6 read kept", rd_data, 32'h0505_0000);
    chk("R6 no strobe", 32'(par_inv), 0);
    // R7 and R9 err only
    step(1, 1, 32'h000A_0000);
    chk("R7 err high", 32'(err_clr), 1);
    chk("R9 par stays low", 32'(par_inv), 0);
    step(0, 0, 0);
    chk("R7 err low", 32'(err_clr), 0);
    // R8 other bits ignored, illegal par key
    step(1, 1, 32'hFFFA_FFFF);
    chk("R8 read masked", rd_data, 32'h050A_0000);
    step(0, 0, 0);
    // R9 both
    step(1, 1, 32'h0A0A_0000);
    chk("R9 both high", {30'd0, par_inv, err_clr}, 3);
    step(0, 0, 0);
    // R3 back-to-back
    step(1, 1, 32'h0A00_0000);
    step(1, 1, 32'h0A00_0000);
    chk("R3 second trigger", 32'(par_inv), 1);
    step(0, 0, 0);
    chk("R3 ends", 32'(par_inv), 0);
    // R6 idle key during strobe
    step(1, 1, 32'h0A00_0000);
    step(1, 1, 32'h0500_0000);
    chk("R6 idle write", rd_data, 32'h0505_0000);
    // mixed stream
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      int sel;
      d = $urandom;
      sel = $urandom_range(0, 3);
      if (sel == 0) d[27:24] = 4'hA;
      if (sel == 1) d[19:16] = 4'hA;
      if (sel == 2) d[27:24] = 4'h5;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, d);
    end
    finish_run();
  end
endmodule